// File: doc/BRIEF.md
# Single-Cycle Three-Bit-Error Correcting Page Decoder

This block repairs a 256-bit data page read from a memory whose cells may flip. The page is stored together with 27 check bits as a 283-bit word of a shortened binary BCH code over GF(2^9). The decoder is one combinational cone with no clock and no state: the stored word goes in, and the repaired page comes out in the same cycle, along with a verdict and the number of bits it flipped.

Three stages make up the datapath. First, three odd-power syndromes are formed in parallel from the received word. Second, the coefficients of the error-locator polynomial are written directly as closed-form expressions of those syndromes. There is one short formula for the single-error case and one shared formula for two and three errors; no iterative solver is used. Third, the locator is evaluated at the inverse field element of all 283 positions at once. Every position where it vanishes is flipped, provided the number of such positions equals the degree of the locator. Any inconsistency is reported as uncorrectable, and the page then leaves unchanged.

Top module: `bch3_decoder`

## Requirements
- R1: A valid codeword raises `clean_o` alone, reports `fix_count_o` = 0 and returns `word_i[282:27]` unchanged on `page_o`.
- R2: A single flipped bit at any of the 283 positions, parity or data, is repaired. `page_o` then equals the original page, `repaired_o` is the only flag raised, and `fix_count_o` = 1.
- R3: Any two flipped bits at distinct positions are repaired, with `repaired_o` raised and `fix_count_o` = 2.
- R4: Any three flipped bits at distinct positions are repaired, with `repaired_o` raised and `fix_count_o` = 3. `page_o` never differs from the received page in more bits than `fix_count_o`.
- R5: Exactly one of `clean_o`, `repaired_o` and `uncorrectable_o` is high for every input word.
- R6: When `uncorrectable_o` is high, `page_o` equals `word_i[282:27]` and `fix_count_o` = 0. This holds when the root count differs from the locator degree, and when the two/three-error denominator S1^3 + S3 is zero.
- R7: Four flipped bits never yield `clean_o`. They are either reported as uncorrectable, or decoded to a different valid codeword, in which case `fix_count_o` = 3 and `page_o` differs from the original page.
- R8: Word layout: bit i of `word_i` is the coefficient of x^i. The page occupies bits 282..27, and bits 26..0 hold the remainder of page(x)·x^27 divided by the generator polynomial. That polynomial is the product of the minimal polynomials of α, α^3 and α^5 in GF(2^9), built on x^9 + x^4 + 1 with α = x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 283 | Received codeword, page in the upper 256 bits, check bits below |
| page_o | output | 256 | Repaired page, or the received page when uncorrectable |
| clean_o | output | 1 | No error detected |
| repaired_o | output | 1 | One to three bits were flipped back |
| uncorrectable_o | output | 1 | Error pattern could not be resolved |
| fix_count_o | output | 2 | Number of bits flipped (0 when clean or uncorrectable) |

## Verification
The hardest condition to reach from the ports is the one where four flips make the decoder land on a neighbouring codeword. In that case the locator finds three valid roots and the block claims a repair, so the result cannot simply be compared with the original page. The bench encodes random pages with its own generator polynomial and injects a few hundred random four-bit patterns. For each one it accepts only an uncorrectable verdict with the received page passed through, or a three-bit repair that yields a page different from the original. It also requires that uncorrectable verdicts actually occur. Fixed edge patterns are added alongside the random ones: flips at bit 0, at bit 282 and straddling the parity/data boundary at bits 26 and 27.

// File: rtl/bch3_pkg.sv
package bch3_pkg;

    localparam int GF_M     = 9;
    localparam int GF_ORDER = (1 << GF_M) - 1;
    localparam logic [GF_M-1:0] GF_POLY_LO = 9'h011;   // x^9 = x^4 + 1
    localparam int T_CORR   = 3;
    localparam int PAR_W    = GF_M * T_CORR;

    typedef logic [GF_M-1:0] gf_t;

    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_SINGLE = 2'd1,
        CLS_MULTI  = 2'd2,
        CLS_BAD    = 2'd3
    } err_class_e;

    typedef struct packed {
        gf_t s1;
        gf_t s3;
        gf_t s5;
    } syndrome_t;

    typedef struct packed {
        gf_t        c1;
        gf_t        c2;
        gf_t        c3;
        logic [1:0] degree;
        err_class_e cls;
    } locator_t;

    // Shift-and-add product reduced by the field polynomial.
    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = sh[GF_M-1] ? ((sh << 1) ^ GF_POLY_LO) : (sh << 1);
        end
        return acc;
    endfunction

    function automatic gf_t gf_sq(gf_t a);
        return gf_mul(a, a);
    endfunction

    // Square-and-multiply power, exponent below 2^(GF_M+1).
    function automatic gf_t gf_pow(gf_t a, int e);
        gf_t r;
        gf_t b;
        r = gf_t'(1);
        b = a;
        for (int k = 0; k <= GF_M; k++) begin
            if (e[k]) r = gf_mul(r, b);
            b = gf_mul(b, b);
        end
        return r;
    endfunction

    // Inverse through a^(2^m - 2); zero maps to zero.
    function automatic gf_t gf_inv(gf_t a);
        return gf_pow(a, GF_ORDER - 1);
    endfunction

    function automatic gf_t gf_alpha(int e);
        return gf_pow(gf_t'(2), e % GF_ORDER);
    endfunction

    function automatic gf_t gf_alpha_neg(int e);
        return gf_pow(gf_t'(2), (GF_ORDER - (e % GF_ORDER)) % GF_ORDER);
    endfunction

endpackage

// File: rtl/bch3_syndrome.sv
module bch3_syndrome
    import bch3_pkg::*;
#(
    parameter int CW_W = 283
) (
    input  logic [CW_W-1:0] word_i,
    output syndrome_t       syn_o
);

    gf_t syn_arr [T_CORR];

    for (genvar t = 0; t < T_CORR; t++) begin : g_pow
        logic [CW_W-1:0][GF_M-1:0] term;

        for (genvar i = 0; i < CW_W; i++) begin : g_bit
            localparam gf_t KPOW = gf_alpha((2 * t + 1) * i);
            assign term[i] = word_i[i] ? KPOW : '0;
        end

        always_comb begin
            syn_arr[t] = '0;
            for (int i = 0; i < CW_W; i++) begin
                syn_arr[t] = syn_arr[t] ^ term[i];
            end
        end
    end

    assign syn_o.s1 = syn_arr[0];
    assign syn_o.s3 = syn_arr[1];
    assign syn_o.s5 = syn_arr[2];

endmodule

// File: rtl/bch3_locator.sv
module bch3_locator
    import bch3_pkg::*;
(
    input  syndrome_t syn_i,
    output locator_t  loc_o
);

    gf_t s1_sq;
    gf_t s1_cu;
    gf_t s1_p5;
    gf_t dlt;
    gf_t numer;
    gf_t c2_raw;
    gf_t c3_raw;
    logic all_zero;
    logic one_err;

    always_comb begin
        s1_sq  = gf_sq(syn_i.s1);
        s1_cu  = gf_mul(s1_sq, syn_i.s1);
        s1_p5  = gf_mul(s1_cu, s1_sq);
        dlt    = s1_cu ^ syn_i.s3;
        numer  = gf_mul(s1_sq, syn_i.s3) ^ syn_i.s5;
        c2_raw = gf_mul(numer, gf_inv(dlt));
        c3_raw = dlt ^ gf_mul(syn_i.s1, c2_raw);

        all_zero = (syn_i.s1 == '0) && (syn_i.s3 == '0) && (syn_i.s5 == '0);
        one_err  = (s1_cu == syn_i.s3) && (s1_p5 == syn_i.s5);

        loc_o     = '0;
        loc_o.cls = CLS_CLEAN;
        if (all_zero) begin
            loc_o.cls = CLS_CLEAN;
        end else if (one_err) begin
            loc_o.c1     = syn_i.s1;
            loc_o.degree = 2'd1;
            loc_o.cls    = CLS_SINGLE;
        end else if (dlt == '0) begin
            loc_o.cls = CLS_BAD;
        end else if (c3_raw != '0) begin
            loc_o.c1     = syn_i.s1;
            loc_o.c2     = c2_raw;
            loc_o.c3     = c3_raw;
            loc_o.degree = 2'd3;
            loc_o.cls    = CLS_MULTI;
        end else if (c2_raw != '0) begin
            loc_o.c1     = syn_i.s1;
            loc_o.c2     = c2_raw;
            loc_o.degree = 2'd2;
            loc_o.cls    = CLS_MULTI;
        end else begin
            loc_o.cls = CLS_BAD;
        end
    end

endmodule

// File: rtl/bch3_rootsearch.sv
module bch3_rootsearch
    import bch3_pkg::*;
#(
    parameter int DATA_W = 256,
    localparam int CW_W  = DATA_W + PAR_W,
    localparam int CNT_W = $clog2(CW_W + 1)
) (
    input  locator_t          loc_i,
    output logic [DATA_W-1:0] data_hit_o,
    output logic [CNT_W-1:0]  root_cnt_o
);

    logic [CW_W-1:0] hit;

    for (genvar i = 0; i < CW_W; i++) begin : g_pos
        localparam gf_t KINV1 = gf_alpha_neg(i);
        localparam gf_t KINV2 = gf_alpha_neg(2 * i);
        localparam gf_t KINV3 = gf_alpha_neg(3 * i);
        gf_t value;

        always_comb begin
            value = gf_t'(1) ^ gf_mul(loc_i.c1, KINV1)
                             ^ gf_mul(loc_i.c2, KINV2)
                             ^ gf_mul(loc_i.c3, KINV3);
        end

        assign hit[i] = (value == '0);
    end

    always_comb begin
        root_cnt_o = '0;
        for (int i = 0; i < CW_W; i++) begin
            root_cnt_o = root_cnt_o + CNT_W'(hit[i]);
        end
    end

    assign data_hit_o = hit[CW_W-1:PAR_W];

endmodule

// File: rtl/bch3_decoder.sv
module bch3_decoder
    import bch3_pkg::*;
#(
    parameter int DATA_W = 256,
    localparam int CW_W  = DATA_W + PAR_W,
    localparam int CNT_W = $clog2(CW_W + 1)
) (
    input  logic [CW_W-1:0]   word_i,
    output logic [DATA_W-1:0] page_o,
    output logic              clean_o,
    output logic              repaired_o,
    output logic              uncorrectable_o,
    output logic [1:0]        fix_count_o
);

    syndrome_t          syn;
    locator_t           loc;
    logic [DATA_W-1:0]  data_hit;
    logic [CNT_W-1:0]   root_cnt;
    logic [DATA_W-1:0]  rx_page;
    logic               decodable;

    bch3_syndrome #(.CW_W(CW_W)) u_syn (
        .word_i (word_i),
        .syn_o  (syn)
    );

    bch3_locator u_loc (
        .syn_i (syn),
        .loc_o (loc)
    );

    bch3_rootsearch #(.DATA_W(DATA_W)) u_roots (
        .loc_i      (loc),
        .data_hit_o (data_hit),
        .root_cnt_o (root_cnt)
    );

    assign rx_page   = word_i[CW_W-1:PAR_W];
    assign decodable = ((loc.cls == CLS_SINGLE) || (loc.cls == CLS_MULTI))
                       && (root_cnt == CNT_W'(loc.degree));

    assign clean_o         = (loc.cls == CLS_CLEAN);
    assign repaired_o      = decodable;
    assign uncorrectable_o = !clean_o && !decodable;
    assign fix_count_o     = decodable ? loc.degree : 2'd0;
    assign page_o          = decodable ? (rx_page ^ data_hit) : rx_page;

endmodule

// File: rtl/bch3_decoder_chk.sv
module bch3_decoder_chk #(
    parameter int DATA_W = 256
) (
    input logic [DATA_W-1:0] rx_page_i,
    input logic [DATA_W-1:0] page_i,
    input logic              clean_i,
    input logic              repaired_i,
    input logic              uncorr_i,
    input logic [1:0]        fix_count_i
);

    always_comb begin
        AST_ONE_VERDICT: assert ($countones({clean_i, repaired_i, uncorr_i}) == 1); // R5
        if (clean_i) begin
            AST_CLEAN_PASSTHRU: assert (page_i == rx_page_i && fix_count_i == 2'd0); // R1
        end
        if (uncorr_i) begin
            AST_BAD_PASSTHRU: assert (page_i == rx_page_i && fix_count_i == 2'd0); // R6
        end
        if (repaired_i) begin
            AST_FIX_NONZERO: assert (fix_count_i != 2'd0); // R2
            AST_FIX_BOUNDED: assert ($countones(page_i ^ rx_page_i) <= int'(fix_count_i)); // R4
        end
    end

endmodule

bind bch3_decoder bch3_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .rx_page_i   (word_i[CW_W-1:bch3_pkg::PAR_W]),
    .page_i      (page_o),
    .clean_i     (clean_o),
    .repaired_i  (repaired_o),
    .uncorr_i    (uncorrectable_o),
    .fix_count_i (fix_count_o)
);

// File: tb/bch3_decoder_tb.sv
module bch3_decoder_tb;

    localparam int DW = 256;
    localparam int PW = 27;
    localparam int CW = DW + PW;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] word = '0;
    logic [DW-1:0] page;
    logic          clean, repaired, uncorr;
    logic [1:0]    fcnt;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [PW:0] gpoly;

    always #10 clk = ~clk;

    bch3_decoder u_dut (
        .word_i          (word),
        .page_o          (page),
        .clean_o         (clean),
        .repaired_o      (repaired),
        .uncorrectable_o (uncorr),
        .fix_count_o     (fcnt)
    );

    always @(posedge clk) begin
        if (!rst) begin
            cyc = cyc + 1;
            if (cyc > WATCHDOG) begin
                n_fail = n_fail + 1;
                $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cyc, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    // Bench-side field arithmetic, x^9 + x^4 + 1.
    function automatic logic [8:0] fmul(logic [8:0] a, logic [8:0] b);
        logic [8:0] acc;
        logic [8:0] sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < 9; k++) begin
            if (b[k]) acc ^= sh;
            sh = sh[8] ? ({sh[7:0], 1'b0} ^ 9'h011) : {sh[7:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [8:0] fexp(int e);
        logic [8:0] r;
        r = 9'd1;
        for (int k = 0; k < e; k++) r = fmul(r, 9'd2);
        return r;
    endfunction

    // Product of the minimal polynomials of alpha, alpha^3, alpha^5 (R8).
    function automatic logic [PW:0] make_gen();
        logic [PW:0] g;
        logic [PW:0] nxt;
        logic [8:0]  m [10];
        logic [8:0]  beta;
        g = 1;
        for (int j = 1; j <= 5; j += 2) begin
            for (int k = 0; k < 10; k++) m[k] = '0;
            m[0] = 9'd1;
            beta = fexp(j);
            for (int c = 0; c < 9; c++) begin
                for (int k = 9; k > 0; k--) m[k] = m[k-1] ^ fmul(m[k], beta);
                m[0] = fmul(m[0], beta);
                beta = fmul(beta, beta);
            end
            nxt = '0;
            for (int k = 0; k < 10; k++) if (m[k][0]) nxt ^= (g << k);
            g = nxt;
        end
        return g;
    endfunction

    function automatic logic [CW-1:0] encode(logic [DW-1:0] d);
        logic [CW-1:0] r;
        logic [CW-1:0] gx;
        r  = {d, {PW{1'b0}}};
        gx = {{(CW-PW-1){1'b0}}, gpoly};
        for (int i = CW - 1; i >= PW; i--) begin
            if (r[i]) r ^= (gx << (i - PW));
        end
        return {d, r[PW-1:0]};
    endfunction

    function automatic logic [DW-1:0] rand_page();
        logic [DW-1:0] d;
        for (int k = 0; k < DW / 32; k++) d[k*32 +: 32] = $urandom;
        return d;
    endfunction

    function automatic logic [CW-1:0] rand_flips(int n);
        logic [CW-1:0] f;
        int placed;
        int p;
        f = '0;
        placed = 0;
        while (placed < n) begin
            p = $urandom_range(CW - 1, 0);
            if (!f[p]) begin
                f[p] = 1'b1;
                placed++;
            end
        end
        return f;
    endfunction

    task automatic check(string req, string what, bit pass, string act, string exp);
        n_chk++;
        if (!pass) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [CW-1:0] v);
        @(posedge clk);
        word <= v;
        @(negedge clk);
    endtask

    // Apply a page with a given flip mask and expect an exact repair.
    task automatic run_fix(string req, logic [DW-1:0] d, logic [CW-1:0] flips, int n);
        apply(encode(d) ^ flips);
        check("R5", "one verdict", $countones({clean, repaired, uncorr}) == 1,
              $sformatf("%b%b%b", clean, repaired, uncorr), "one-hot");
        if (n == 0) check(req, "clean flag", clean == 1'b1, $sformatf("%b", clean), "1");
        else        check(req, "repaired flag", repaired == 1'b1, $sformatf("%b", repaired), "1");
        check(req, "fix count", int'(fcnt) == n, $sformatf("%0d", fcnt), $sformatf("%0d", n));
        check(req, "page", page == d, $sformatf("%h", page), $sformatf("%h", d));
    endtask

    task automatic t_reset_state();
        apply('0);
        check("R1", "all-zero word clean", clean == 1'b1 && repaired == 1'b0 && uncorr == 1'b0,
              $sformatf("%b%b%b", clean, repaired, uncorr), "100");
        check("R1", "all-zero page", page == '0 && fcnt == 2'd0,
              $sformatf("%h/%0d", page, fcnt), "0/0");
    endtask

    task automatic t_no_error();
        run_fix("R8", {DW{1'b1}}, '0, 0);
        for (int k = 0; k < 16; k++) run_fix("R1", rand_page(), '0, 0);
    endtask

    task automatic t_single_walk();
        for (int p = 0; p < CW; p++) begin
            logic [CW-1:0] f;
            f = '0;
            f[p] = 1'b1;
            run_fix("R2", rand_page(), f, 1);
        end
    endtask

    task automatic t_double();
        logic [CW-1:0] f;
        f = '0; f[0] = 1'b1; f[CW-1] = 1'b1;
        run_fix("R3", rand_page(), f, 2);
        f = '0; f[PW-1] = 1'b1; f[PW] = 1'b1;
        run_fix("R3", rand_page(), f, 2);
        for (int k = 0; k < 150; k++) run_fix("R3", rand_page(), rand_flips(2), 2);
    endtask

    task automatic t_triple();
        logic [CW-1:0] f;
        f = '0; f[0] = 1'b1; f[1] = 1'b1; f[2] = 1'b1;
        run_fix("R4", rand_page(), f, 3);
        f = '0; f[CW-1] = 1'b1; f[CW-2] = 1'b1; f[CW-3] = 1'b1;
        run_fix("R4", rand_page(), f, 3);
        f = '0; f[PW-1] = 1'b1; f[PW] = 1'b1; f[PW+1] = 1'b1;
        run_fix("R4", '0, f, 3);
        for (int k = 0; k < 200; k++) run_fix("R4", rand_page(), rand_flips(3), 3);
    endtask

    task automatic t_four();
        int n_bad;
        n_bad = 0;
        for (int k = 0; k < 300; k++) begin
            logic [DW-1:0] d;
            logic [CW-1:0] rx;
            d  = rand_page();
            rx = encode(d) ^ rand_flips(4);
            apply(rx);
            check("R7", "never clean", clean == 1'b0, $sformatf("%b", clean), "0");
            if (uncorr) begin
                n_bad++;
                check("R6", "page passthrough", page == rx[CW-1:PW],
                      $sformatf("%h", page), $sformatf("%h", rx[CW-1:PW]));
                check("R6", "count zero", fcnt == 2'd0, $sformatf("%0d", fcnt), "0");
            end else begin
                check("R7", "alias needs three flips", repaired == 1'b1 && fcnt == 2'd3,
                      $sformatf("%b/%0d", repaired, fcnt), "1/3");
                check("R7", "alias page differs", page != d,
                      $sformatf("%h", page), "not original");
            end
        end
        check("R6", "uncorrectable verdicts seen", n_bad > 0, $sformatf("%0d", n_bad), ">0");
    endtask

    task automatic t_garbage();
        for (int k = 0; k < 60; k++) begin
            logic [CW-1:0] rx;
            rx = {rand_page(), 27'($urandom)};
            apply(rx);
            check("R5", "one verdict on noise", $countones({clean, repaired, uncorr}) == 1,
                  $sformatf("%b%b%b", clean, repaired, uncorr), "one-hot");
            if (uncorr) begin
                check("R6", "noise passthrough", page == rx[CW-1:PW] && fcnt == 2'd0,
                      $sformatf("%h/%0d", page, fcnt), $sformatf("%h/0", rx[CW-1:PW]));
            end
        end
    endtask

    initial begin
        gpoly = make_gen();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_no_error();
        t_single_walk();
        t_double();
        t_triple();
        t_four();
        t_garbage();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule